// File: doc/BRIEF.md
# Programmable Product-Term Chip-Select Decoder

This block turns a wide set of address, page, port and bus-strobe signals into seven chip selects. Each select is one programmable AND term: for every select and every input, a stored 2-bit code says whether the term needs that input high, needs it low, does not care about it, or is forced false by it. The selects cover four flash blocks, an SRAM block, an I/O decoder enable and a boot memory. The selects follow their inputs through logic only, with no register in the path.

A 4-bit page register is one of the term inputs, so a select can depend on the page and on the address together. A small I/O sub-decoder works behind the I/O enable. It compares the low address byte with a programmable base that is aligned to 8, and it raises one of eight one-hot register selects. All codes, the page register and the I/O base are written through a single write port with write-enable, address and data. Reset forces every term false, so no select can assert before the block has been programmed.

Top module: `pt_cs_decoder`

## Requirements
- R1: After reset every input code is 11 and the page and I/O base registers are zero, so all seven selects and all eight I/O selects stay 0 whatever the inputs are.
- R2: Code 01 for input j of a term makes that term need input j at 1.
- R3: Code 10 for input j of a term makes that term need input j at 0.
- R4: Code 00 makes a term ignore input j. A term whose codes are all 00 is constant 1.
- R5: Code 11 on any input of a term forces that term to 0.
- R6: Term input index layout: 0-1 address bits 0 and 1 (addr_lo[1:0]); 2-9 addr_hi[7:0]; 10-13 page register; 14-21 port_a; 22-29 port_b; 30-37 port_e; 38-45 port_c; 46-53 port_d; 54 rd_strobe; 55 wr_strobe; 56 clk_level; 57 rst_level; 58 chip-select-in.
- R7: A write to address 0x200 loads cfg_wdata[3:0] into the page register. The new value takes effect from the next clock edge.
- R8: The chip-select-in term input (index 58) is csi_in OR pdn_in.
- R9: Term 0..3 drives flash_sel[0..3], term 4 drives sram_sel, term 5 drives io_en and term 6 drives boot_sel.
- R10: A write to an address with bit 9 = 0 loads code cfg_wdata[1:0] for term cfg_addr[8:6] and input cfg_addr[5:0]. The code takes effect from the next clock edge, and the selects respond to their inputs with no clock delay.
- R11: A write to 0x201 loads the I/O base. While io_en is 1 and addr_lo[7:3] equals base[7:3], io_sel is one-hot with bit addr_lo[2:0] set. Otherwise it is zero.
- R12: io_sel is all zero whenever io_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 10 | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data |
| addr_lo | input | 8 | Address bits 7..0 |
| addr_hi | input | 8 | Address bits 15..8 |
| port_a | input | 8 | Port A inputs |
| port_b | input | 8 | Port B inputs |
| port_c | input | 8 | Port C inputs |
| port_d | input | 8 | Port D inputs |
| port_e | input | 8 | Port E inputs |
| rd_strobe | input | 1 | Bus read strobe |
| wr_strobe | input | 1 | Bus write strobe |
| clk_level | input | 1 | External clock pin level, used as a term input |
| rst_level | input | 1 | External reset pin level, used as a term input |
| csi_in | input | 1 | Chip-select-in line |
| pdn_in | input | 1 | Power-down indication |
| flash_sel | output | 4 | Flash block selects |
| sram_sel | output | 1 | SRAM select |
| io_en | output | 1 | I/O decoder enable |
| boot_sel | output | 1 | Boot memory select |
| io_sel | output | 8 | One-hot I/O register selects |

## Verification
Directed single-input terms set one code against a field that is otherwise ignored. They separate the need-high, need-low, ignore and force-false codes, and they pin each field to its index in the input vector, including the page register and the OR of csi_in with pdn_in. Random terms with zero to three cared-for inputs, plus an occasional force-false code, are driven with random buses. These show that every input of every term is combined by AND, and they exercise the mapping of terms to outputs. I/O patterns place the address inside and outside the window of a random base, with the enable both on and off. This separates the match on the base from the one-hot decode of the low three bits.

// File: rtl/pt_cs_decoder.sv
module pt_cs_decoder #(
  parameter int NUM_TERMS = 7,
  parameter int AW        = 10,
  parameter int DW        = 8,
  parameter int PAGE_W    = 4,
  parameter int IO_WIN    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [7:0]       addr_lo,
  input  logic [7:0]       addr_hi,
  input  logic [7:0]       port_a,
  input  logic [7:0]       port_b,
  input  logic [7:0]       port_c,
  input  logic [7:0]       port_d,
  input  logic [7:0]       port_e,
  input  logic             rd_strobe,
  input  logic             wr_strobe,
  input  logic             clk_level,
  input  logic             rst_level,
  input  logic             csi_in,
  input  logic             pdn_in,
  output logic [3:0]       flash_sel,
  output logic             sram_sel,
  output logic             io_en,
  output logic             boot_sel,
  output logic [IO_WIN-1:0] io_sel
);
  localparam int NUM_IN    = 2 + 8 + PAGE_W + 5 * 8 + 5;
  localparam int IN_BITS   = $clog2(NUM_IN);
  localparam int TERM_BITS = $clog2(NUM_TERMS);
  localparam int WIN_BITS  = $clog2(IO_WIN);
  localparam logic [AW-1:0] PAGE_ADDR = AW'(1) << (AW - 1);
  localparam logic [AW-1:0] BASE_ADDR = PAGE_ADDR + AW'(1);

  logic [1:0]        code_q [NUM_TERMS][NUM_IN];
  logic [PAGE_W-1:0] page_q;
  logic [7:0]        base_q;
  logic [NUM_IN-1:0] in_vec;
  logic [NUM_TERMS-1:0] term;

  wire [TERM_BITS-1:0] wr_term = cfg_addr[IN_BITS +: TERM_BITS];
  wire [IN_BITS-1:0]   wr_in   = cfg_addr[IN_BITS-1:0];
  wire arr_wr = cfg_we && !cfg_addr[AW-1]
                && (int'(wr_term) < NUM_TERMS) && (int'(wr_in) < NUM_IN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_TERMS; t++)
        for (int j = 0; j < NUM_IN; j++)
          code_q[t][j] <= 2'b11;
      page_q <= '0;
      base_q <= '0;
    end else if (cfg_we) begin
      if (arr_wr) code_q[wr_term][wr_in] <= cfg_wdata[1:0];
      if (cfg_addr == PAGE_ADDR) page_q <= cfg_wdata[PAGE_W-1:0];
      if (cfg_addr == BASE_ADDR) base_q <= cfg_wdata[7:0];
    end
  end

  assign in_vec = {csi_in | pdn_in, rst_level, clk_level, wr_strobe, rd_strobe,
                   port_d, port_c, port_e, port_b, port_a, page_q, addr_hi,
                   addr_lo[1:0]};

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    always_comb begin
      term[t] = 1'b1;
      for (int j = 0; j < NUM_IN; j++) begin
        case (code_q[t][j])
          2'b01:   if (!in_vec[j]) term[t] = 1'b0;
          2'b10:   if (in_vec[j])  term[t] = 1'b0;
          2'b11:   term[t] = 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign flash_sel = term[3:0];
  assign sram_sel  = term[4];
  assign io_en     = term[5];
  assign boot_sel  = term[6];

  wire io_hit = io_en && (addr_lo[7:WIN_BITS] == base_q[7:WIN_BITS]);
  assign io_sel = io_hit ? (IO_WIN'(1) << addr_lo[WIN_BITS-1:0]) : '0;

  // R12
  io_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_en |-> io_sel == '0);

  // R11
  io_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(io_sel));

  // R7
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == PAGE_ADDR) |=> page_q == $past(cfg_wdata[PAGE_W-1:0]));

  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == PAGE_ADDR) |=> $stable(page_q));

  // R11
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == BASE_ADDR) |=> $stable(base_q));
endmodule

// File: tb/pt_cs_decoder_tb.sv
module pt_cs_decoder_tb_top;
  localparam int NT = 7;
  localparam int NI = 59;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [9:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] addr_lo = 0, addr_hi = 0, port_a = 0, port_b = 0, port_c = 0, port_d = 0, port_e = 0;
  logic rd_strobe = 0, wr_strobe = 0, clk_level = 0, rst_level = 0, csi_in = 0, pdn_in = 0;
  logic [3:0] flash_sel;
  logic sram_sel, io_en, boot_sel;
  logic [7:0] io_sel;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] m_code [NT][NI];
  logic [3:0] m_page;
  logic [7:0] m_base;

  pt_cs_decoder dut_i (.*);

  always #5 clk = ~clk;

  function automatic logic [NI-1:0] vec();
    return {csi_in | pdn_in, rst_level, clk_level, wr_strobe, rd_strobe,
            port_d, port_c, port_e, port_b, port_a, m_page, addr_hi, addr_lo[1:0]};
  endfunction

  function automatic logic [NT-1:0] exp_sel();
    logic [NI-1:0] v = vec();
    logic [NT-1:0] r;
    for (int t = 0; t < NT; t++) begin
      r[t] = 1'b1;
      for (int j = 0; j < NI; j++)
        if (m_code[t][j] == 2'b11 || (m_code[t][j] == 2'b01 && !v[j]) ||
            (m_code[t][j] == 2'b10 && v[j])) r[t] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_io(logic en);
    if (en && addr_lo[7:3] == m_base[7:3]) return 8'(1) << addr_lo[2:0];
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [14:0] act, logic [14:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic check_all(string tag);
    logic [NT-1:0] e = exp_sel();
    #2;
    check(tag, {io_sel, boot_sel, io_en, sram_sel, flash_sel},
          {exp_io(e[5]), e});
  endtask

  task automatic wr(logic [9:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a == 10'h200) m_page = d[3:0];
    else if (a == 10'h201) m_base = d;
    else if (!a[9] && a[8:6] < NT && a[5:0] < NI) m_code[a[8:6]][a[5:0]] = d[1:0];
  endtask

  task automatic set_code(int t, int j, logic [1:0] c);
    wr({1'b0, 3'(t), 6'(j)}, {6'b0, c});
  endtask

  task automatic fill_term(int t, logic [1:0] c);
    for (int j = 0; j < NI; j++) set_code(t, j, c);
  endtask

  task automatic rand_inputs();
    {addr_lo, addr_hi, port_a, port_b} = $urandom;
    {port_c, port_d, port_e} = 24'($urandom);
    {rd_strobe, wr_strobe, clk_level, rst_level, csi_in, pdn_in} = 6'($urandom);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int t = 0; t < NT; t++) for (int j = 0; j < NI; j++) m_code[t][j] = 2'b11;
    m_page = 0; m_base = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: nothing asserts after reset
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); rand_inputs();
      #2 check("R1", {io_sel, boot_sel, io_en, sram_sel, flash_sel}, 15'h0);
    end

    // R4: all-ignore term is constant true; R9 output position
    fill_term(0, 2'b00);
    @(negedge clk); rand_inputs(); #2 check("R4", {11'b0, flash_sel}, 15'h1);
    // R5: one force-false code kills it
    set_code(0, 20, 2'b11);
    @(negedge clk); rand_inputs(); #2 check("R5", {11'b0, flash_sel}, 15'h0);
    set_code(0, 20, 2'b00);

    // R2/R6: term 1 needs port_b[3] (index 25) high
    fill_term(1, 2'b00); set_code(1, 25, 2'b01);
    @(negedge clk); rand_inputs(); port_b[3] = 1; #2 check("R2", {11'b0, flash_sel}, 15'h3);
    @(negedge clk); port_b[3] = 0; #2 check("R2", {11'b0, flash_sel}, 15'h1);
    // R3: need-low on rd_strobe (index 54)
    set_code(1, 25, 2'b00); set_code(1, 54, 2'b10);
    @(negedge clk); rd_strobe = 0; #2 check("R3", {11'b0, flash_sel}, 15'h3);
    @(negedge clk); rd_strobe = 1; #2 check("R3", {11'b0, flash_sel}, 15'h1);
    fill_term(0, 2'b11); fill_term(1, 2'b11);

    // R8: boot term needs chip-select-in (index 58)
    fill_term(6, 2'b00); set_code(6, 58, 2'b01);
    @(negedge clk); csi_in = 0; pdn_in = 1; #2 check("R8", {14'b0, boot_sel}, 15'h1);
    @(negedge clk); csi_in = 1; pdn_in = 0; #2 check("R8", {14'b0, boot_sel}, 15'h1);
    @(negedge clk); csi_in = 0; pdn_in = 0; #2 check("R8", {14'b0, boot_sel}, 15'h0);
    fill_term(6, 2'b11);

    // R7: SRAM term needs page 4'b1010 (indices 10..13)
    fill_term(4, 2'b00);
    set_code(4, 10, 2'b10); set_code(4, 11, 2'b01); set_code(4, 12, 2'b10); set_code(4, 13, 2'b01);
    @(negedge clk); #2 check("R7", {14'b0, sram_sel}, 15'h0);
    wr(10'h200, 8'h0A);
    #2 check("R7", {14'b0, sram_sel}, 15'h1);
    wr(10'h200, 8'h0B);
    #2 check("R7", {14'b0, sram_sel}, 15'h0);
    fill_term(4, 2'b11);

    // R11: I/O window
    fill_term(5, 2'b00); wr(10'h201, 8'h28);
    @(negedge clk); addr_lo = 8'h2D; #2 check("R11", {io_sel, 7'b0}, {8'h20, 7'b0});
    @(negedge clk); addr_lo = 8'h30; #2 check("R11", {io_sel, 7'b0}, 15'h0);
    @(negedge clk); addr_lo = 8'h28; #2 check("R11", {io_sel, 7'b0}, {8'h01, 7'b0});
    // R12: enable off blocks I/O selects
    set_code(5, 0, 2'b11);
    @(negedge clk); addr_lo = 8'h2F; #2 check("R12", {io_sel, 7'b0}, 15'h0);

    // R10: random terms under random inputs
    for (int c = 0; c < 6; c++) begin
      for (int t = 0; t < NT; t++) begin
        fill_term(t, 2'b00);
        for (int k = 0; k < int'($urandom_range(0, 3)); k++)
          set_code(t, $urandom_range(0, NI - 1), ($urandom_range(0, 15) == 0) ? 2'b11 : 2'($urandom_range(1, 2)));
      end
      wr(10'h200, 8'($urandom)); wr(10'h201, 8'($urandom));
      for (int n = 0; n < 200; n++) begin
        @(negedge clk); rand_inputs();
        if (n % 3 == 0) addr_lo[7:3] = m_base[7:3];
        check_all("R10");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule